// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block is the write-only control port of an audio converter. A host drives four lines: an active-low select, a shift clock, a serial data line and a latch strobe. While select is low, each rising edge of the shift clock moves one data bit into a 16-bit shift register, most significant bit first. A rising edge of the latch strobe then commits the word. A 3-bit address is taken from the word. Nine data bits go into one of five control registers, and every decoded field is driven out as a plain signal for the rest of the converter.

All four host lines are treated as asynchronous. They pass through a synchronizer into the system clock domain and are edge-detected there. A small state machine tracks the word. It has three states. `ST_IDLE` means no shift clock has arrived since the last commit. `ST_SHIFT` means bits are arriving. `ST_COMMIT` is a single cycle in which the register file takes the word. The transitions are:

- `go_shift`: shift edge seen in `ST_IDLE`.
- `go_commit`: latch edge seen in `ST_IDLE` or `ST_SHIFT`.
- `go_idle`: always taken from `ST_COMMIT`, and taken from `ST_SHIFT` when select rises.

The two channel attenuation values are double-buffered. A write first stages the value. The applied pair changes only when a write carries its load bit. The differential-mode register at address 6 stays locked until bits 8:5 of register 2 hold 1111.

Top module: `ctl3w_port`

## Requirements
- R1: While select is low, each rising shift-clock edge shifts `ctl_sdi` into the word, MSB first. A rising latch edge commits the most recent 16 bits.
- R2: While `ctl_csn` is high, shift-clock and latch edges are ignored and no register changes.
- R3: The address is in word bits 11:9, and word bits 15:12 have no effect. Address 0 is left attenuation, 1 is right attenuation, 2 is control A, 3 is control B and 6 is differential. Writes to addresses 4, 5 and 7 change nothing.
- R4: An attenuation write (address 0 or 1; value in bits 7:0, load bit in bit 8) with load clear updates only the staged value. `att_l`/`att_r` stay unchanged.
- R5: An attenuation write with load set makes both `att_l` and `att_r` take the latest staged values, including the value carried by that write.
- R6: In register 2, bit 0 is `mute`, bit 1 is `deemph_en`, bit 2 is `dac_off` and bits 4:3 are `word_len`.
- R7: In register 3, bit 0 is `fmt_i2s`, bit 1 is `lr_swap`, bit 2 is `att_common`, bit 3 is `slow_roll`, bit 4 is `phase_inv`, bit 5 is `clkout_div2`, bits 7:6 are `deemph_rate` and bit 8 is `zero_det_en`.
- R8: In register 6, bits 5:4 are `diff_mode` and bit 6 is `clkloss_off`. Register 6 is writable only while the last value written to register 2 has bits 8:5 equal to 1111. Otherwise writes to it are ignored.
- R9: After reset, `att_l` and `att_r` read 0xFF and every other output reads 0.
- R10: A latch after fewer or more than 16 shift edges decodes the last 16 bits shifted in, including bits left over from earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_csn | input | 1 | Active-low select for the port |
| ctl_sck | input | 1 | Serial shift clock, rising edge active |
| ctl_sdi | input | 1 | Serial data, MSB first |
| ctl_latch | input | 1 | Latch strobe, rising edge commits the word |
| att_l | output | 8 | Applied left attenuation |
| att_r | output | 8 | Applied right attenuation |
| mute | output | 1 | Soft mute request |
| deemph_en | output | 1 | De-emphasis enable |
| dac_off | output | 1 | Force output to zero |
| word_len | output | 2 | Input word-length code |
| fmt_i2s | output | 1 | I2S format select |
| lr_swap | output | 1 | Frame-clock polarity swap |
| att_common | output | 1 | Use left attenuation for both channels |
| slow_roll | output | 1 | Slow filter roll-off select |
| phase_inv | output | 1 | Output phase invert |
| clkout_div2 | output | 1 | Clock output divide-by-two |
| deemph_rate | output | 2 | De-emphasis rate code |
| zero_det_en | output | 1 | Zero-detect mute enable |
| diff_mode | output | 2 | Differential output mode |
| clkloss_off | output | 1 | Clock-loss detector disable |

## Verification
The bench builds the block with its default parameters. These are a 16-bit word, the address at bits 11:9, a 9-bit data field and a two-stage synchronizer. It toggles the host lines a few system clocks per phase, so every synchronized edge is seen once. With these values every address code can be reached, including the unused ones and the locked register 6. The bench can also send shift counts of 8 and 20 edges, so that leftover bits from an earlier word end up in the address field.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_LSB = 9;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 9;
    localparam int ATT_W    = 8;

    localparam logic [ADDR_W-1:0] ADR_ATT_L = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ATT_R = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CTLA  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CTLB  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DIFF  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } port_state_t;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int          LINES  = 4,
    parameter int          STAGES = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
            end
            assign q_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ctl3w_shifter.sv
module ctl3w_shifter
    import ctl3w_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         csn_s,
    input  logic         sck_s,
    input  logic         sdi_s,
    input  logic         latch_s,
    output logic         wr_en_o,
    output logic [W-1:0] word_o
);
    port_state_t state_q, state_d;
    logic         sck_prev_q, latch_prev_q;
    logic [W-1:0] shreg_q;
    logic         sck_rise, latch_rise, sel;

    assign sel        = !csn_s;
    assign sck_rise   = sck_s && !sck_prev_q;
    assign latch_rise = latch_s && !latch_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev_q   <= 1'b0;
            latch_prev_q <= 1'b0;
            shreg_q      <= '0;
        end else begin
            sck_prev_q   <= sck_s;
            latch_prev_q <= latch_s;
            if (sel && sck_rise) shreg_q <= {shreg_q[W-2:0], sdi_s};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel && latch_rise)    state_d = ST_COMMIT;
                else if (sel && sck_rise) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!sel)                 state_d = ST_IDLE;
                else if (latch_rise)      state_d = ST_COMMIT;
            end
            ST_COMMIT:                    state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_en_o = (state_q == ST_COMMIT);
        word_o  = shreg_q;
    end

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && sck_rise) |=> (shreg_q[0] == $past(sdi_s)));
    assert_no_commit_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && latch_rise) |=> !wr_en_o);
    assert_commit_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
    import ctl3w_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [ATT_W-1:0]  att_l_o,
    output logic [ATT_W-1:0]  att_r_o,
    output logic [DATA_W-1:0] ctla_o,
    output logic [DATA_W-1:0] ctlb_o,
    output logic [2:0]        diff_o
);
    localparam int ATT_LOAD = ATT_W;
    localparam logic [3:0] UNLOCK_KEY = 4'hF;

    logic [ADDR_W-1:0] adr;
    logic [DATA_W-1:0] dat;
    logic [ATT_W-1:0]  stage_l_q, stage_r_q, stage_l_d, stage_r_d;
    logic [ATT_W-1:0]  app_l_q, app_r_q;
    logic [DATA_W-1:0] ctla_q, ctlb_q;
    logic [2:0]        diff_q;
    logic              unlocked;

    assign adr      = word_i[ADDR_LSB +: ADDR_W];
    assign dat      = word_i[DATA_W-1:0];
    assign unlocked = (ctla_q[8:5] == UNLOCK_KEY);

    always_comb begin
        stage_l_d = stage_l_q;
        stage_r_d = stage_r_q;
        if (wr_en_i && adr == ADR_ATT_L) stage_l_d = dat[ATT_W-1:0];
        if (wr_en_i && adr == ADR_ATT_R) stage_r_d = dat[ATT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_l_q <= '1;
            stage_r_q <= '1;
            app_l_q   <= '1;
            app_r_q   <= '1;
            ctla_q    <= '0;
            ctlb_q    <= '0;
            diff_q    <= '0;
        end else begin
            stage_l_q <= stage_l_d;
            stage_r_q <= stage_r_d;
            if (wr_en_i && (adr == ADR_ATT_L || adr == ADR_ATT_R) && dat[ATT_LOAD]) begin
                app_l_q <= stage_l_d;
                app_r_q <= stage_r_d;
            end
            if (wr_en_i && adr == ADR_CTLA) ctla_q <= dat;
            if (wr_en_i && adr == ADR_CTLB) ctlb_q <= dat;
            if (wr_en_i && adr == ADR_DIFF && unlocked) diff_q <= dat[6:4];
        end
    end

    assign att_l_o = app_l_q;
    assign att_r_o = app_r_q;
    assign ctla_o  = ctla_q;
    assign ctlb_o  = ctlb_q;
    assign diff_o  = diff_q;

    assert_staged_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (adr == ADR_ATT_L || adr == ADR_ATT_R) && !dat[ATT_LOAD])
        |=> ($stable(att_l_o) && $stable(att_r_o)));
    assert_load_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && adr == ADR_ATT_L && dat[ATT_LOAD]) |=> (att_l_o == $past(word_i[ATT_W-1:0])));
    assert_load_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && adr == ADR_ATT_R && dat[ATT_LOAD]) |=> (att_r_o == $past(word_i[ATT_W-1:0])));
    assert_locked_diff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ctla_o[8:5] != 4'hF) |=> $stable(diff_o));
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(ctla_o) && $stable(ctlb_o) && $stable(att_l_o) && $stable(att_r_o)));
endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_csn,
    input  logic       ctl_sck,
    input  logic       ctl_sdi,
    input  logic       ctl_latch,
    output logic [7:0] att_l,
    output logic [7:0] att_r,
    output logic       mute,
    output logic       deemph_en,
    output logic       dac_off,
    output logic [1:0] word_len,
    output logic       fmt_i2s,
    output logic       lr_swap,
    output logic       att_common,
    output logic       slow_roll,
    output logic       phase_inv,
    output logic       clkout_div2,
    output logic [1:0] deemph_rate,
    output logic       zero_det_en,
    output logic [1:0] diff_mode,
    output logic       clkloss_off
);
    localparam int LINES = 4;

    logic [LINES-1:0]  raw, synced;
    logic              wr_en;
    logic [WORD_W-1:0] word;
    logic [DATA_W-1:0] ctla, ctlb;
    logic [2:0]        diffr;

    assign raw = {ctl_latch, ctl_sdi, ctl_sck, ctl_csn};

    ctl3w_sync #(.LINES(LINES), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
    );

    ctl3w_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .csn_s(synced[0]), .sck_s(synced[1]), .sdi_s(synced[2]), .latch_s(synced[3]),
        .wr_en_o(wr_en), .word_o(word)
    );

    ctl3w_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .word_i(word),
        .att_l_o(att_l), .att_r_o(att_r), .ctla_o(ctla), .ctlb_o(ctlb), .diff_o(diffr)
    );

    assign mute        = ctla[0];
    assign deemph_en   = ctla[1];
    assign dac_off     = ctla[2];
    assign word_len    = ctla[4:3];
    assign fmt_i2s     = ctlb[0];
    assign lr_swap     = ctlb[1];
    assign att_common  = ctlb[2];
    assign slow_roll   = ctlb[3];
    assign phase_inv   = ctlb[4];
    assign clkout_div2 = ctlb[5];
    assign deemph_rate = ctlb[7:6];
    assign zero_det_en = ctlb[8];
    assign diff_mode   = diffr[1:0];
    assign clkloss_off = diffr[2];
endmodule

// File: tb/ctl3w_port_tb.sv
module ctl3w_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sck = 1'b0, sdi = 1'b0, latch = 1'b0;
    logic [7:0] att_l, att_r;
    logic mute, deemph_en, dac_off, fmt_i2s, lr_swap, att_common, slow_roll;
    logic phase_inv, clkout_div2, zero_det_en, clkloss_off;
    logic [1:0] word_len, deemph_rate, diff_mode;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl3w_port dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_csn(csn), .ctl_sck(sck), .ctl_sdi(sdi),
        .ctl_latch(latch), .att_l(att_l), .att_r(att_r), .mute(mute),
        .deemph_en(deemph_en), .dac_off(dac_off), .word_len(word_len),
        .fmt_i2s(fmt_i2s), .lr_swap(lr_swap), .att_common(att_common),
        .slow_roll(slow_roll), .phase_inv(phase_inv), .clkout_div2(clkout_div2),
        .deemph_rate(deemph_rate), .zero_det_en(zero_det_en),
        .diff_mode(diff_mode), .clkloss_off(clkloss_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n, input bit sel);
        csn = !sel;
        wait_clk(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        latch = 1'b1;
        wait_clk(4);
        latch = 1'b0;
        wait_clk(4);
        csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits({16'h0, w}, 16, 1'b1);
    endtask

    task automatic t_reset();
        chk("R9 att_l", att_l, 8'hFF);
        chk("R9 att_r", att_r, 8'hFF);
        chk("R9 ctla", {mute, deemph_en, dac_off, word_len}, 0);
        chk("R9 ctlb", {fmt_i2s, lr_swap, att_common, slow_roll, phase_inv,
                        clkout_div2, deemph_rate, zero_det_en}, 0);
        chk("R9 diff", {diff_mode, clkloss_off}, 0);
    endtask

    task automatic t_staging();
        send_word(16'h0040);
        chk("R4 left staged", {att_l, att_r}, 16'hFFFF);
        send_word(16'h0230);
        chk("R4 right staged", {att_l, att_r}, 16'hFFFF);
        send_word(16'h0330);
        chk("R5 pair load", {att_l, att_r}, 16'h4030);
    endtask

    task automatic t_address();
        send_word(16'hF120);
        chk("R3 upper bits ignored", {att_l, att_r}, 16'h2030);
        send_word(16'h09FF);
        chk("R3 addr 4 ignored", {att_l, att_r, 3'b0, mute}, 20'h20300);
        send_word(16'h0BFF);
        chk("R3 addr 5 ignored", {mute, fmt_i2s}, 0);
    endtask

    task automatic t_select();
        send_bits({16'h0, 16'h0177}, 16, 1'b0);
        chk("R2 unselected ignored", {att_l, att_r}, 16'h2030);
    endtask

    task automatic t_ctla();
        send_word(16'h041F);
        chk("R6 all set", {mute, deemph_en, dac_off, word_len}, 5'b11111);
        send_word(16'h040A);
        chk("R6 pattern", {mute, deemph_en, dac_off, word_len}, 5'b01001);
    endtask

    task automatic t_ctlb();
        send_word(16'h07FF);
        chk("R7 all set", {fmt_i2s, lr_swap, att_common, slow_roll, phase_inv,
                           clkout_div2, deemph_rate, zero_det_en}, 9'h1FF);
        send_word(16'h06A5);
        chk("R7 pattern", {zero_det_en, deemph_rate, clkout_div2, phase_inv,
                           slow_roll, att_common, lr_swap, fmt_i2s}, 9'h0A5);
    endtask

    task automatic t_diff();
        send_word(16'h0C70);
        chk("R8 locked", {diff_mode, clkloss_off}, 0);
        send_word(16'h05E0);
        send_word(16'h0C50);
        chk("R8 unlocked", {diff_mode, clkloss_off}, 3'b011);
        send_word(16'h0400);
        send_word(16'h0C20);
        chk("R8 relocked", {diff_mode, clkloss_off}, 3'b011);
    endtask

    task automatic t_count();
        send_bits({12'h0, 4'hA, 16'h0155}, 20, 1'b1);
        chk("R10 long word", {att_l, att_r}, 16'h5530);
        send_bits(32'h01, 8, 1'b1);
        chk("R10 short word", {mute, deemph_en, dac_off, word_len}, 5'b10000);
        chk("R1 att after short", {att_l, att_r}, 16'h5530);
    endtask

    initial begin
        fork
            begin
                wait_clk(150000);
                if (!done) begin
                    checks++;
                    errors++;
                    $display("FAIL watchdog actual=hung expected=done");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_staging();
        t_address();
        t_select();
        t_ctla();
        t_ctlb();
        t_diff();
        t_count();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule